// File: doc/BRIEF.md
# SPI Configuration Register Port with Write Lock

This block is a four-wire SPI slave that gives a host access to a 128-address byte-wide register space. Each frame starts with a command byte. Its top bit selects a write or a read, and its lower seven bits give the start address. Each further byte in the same frame moves to the next address. The address wraps from the top of the space back to zero. The SPI pins are brought into the system clock domain and oversampled there, so the SPI clock must run well below the system clock (at least eight system cycles per SPI half period).

The space holds several kinds of register:
- a fixed identification byte;
- a latched interrupt status byte, fed by event inputs from neighbouring logic, which clears the bits a host has read;
- a lock control address;
- a band of protected configuration bytes, which accept writes only after a two-write key sequence;
- plain configuration bytes.

All stored configuration bytes are presented on a flat output bus for use by other logic.

Top module: `spi_regport`

## Requirements
- R1: While `spi_cs_n` is high, `spi_miso_oe` is 0 and the SPI clock and data pins have no effect on any register.
- R2: MOSI is sampled on rising SCLK edges, MSB first. MISO changes only after falling SCLK edges, MSB first.
- R3: In the first byte of a frame, bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6:0 are the start address.
- R4: Each further data byte in a frame uses the address one above the previous one. After 0x7F the address returns to 0x00.
- R5: Address 0x00 always reads 0xA6. A write to it is discarded, and the address still advances.
- R6: While locked, writes to 0x11–0x27 are discarded and the address still advances. Addresses 0x28–0x7F read 0x00 and discard writes.
- R7: The protected band unlocks only when 0xBA is written to 0x10 and the very next byte operation (read or write, in any frame) is a write of 0xBE to 0x10.
- R8: Any other byte written to 0x10 locks the band. A read of 0x10 returns 0x01 when the band is unlocked and 0x00 when it is locked.
- R9: Address 0x0C latches `int_event_i` bits (bit n to bit n). A completed read clears only the bits it returned. An event still present sets its bit again. `irq_pending_o` is high while any bit is latched.
- R10: A byte cut short by `spi_cs_n` rising has no effect: no write, no interrupt clear, and no step in the lock sequence.
- R11: Bits without storage read 0: address 0x01 keeps bits 1:0 only, and address 0x11 keeps bit 0 only.
- R12: The first bit of read data appears on MISO after the falling SCLK edge that follows the eighth command bit. Before that edge, MISO is 0.
- R13: After reset, the band is locked, all configuration bytes are 0, no interrupt is latched, and MISO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| int_event_i | input | 8 | Interrupt event inputs, set latched status bits |
| irq_pending_o | output | 1 | High while any interrupt status bit is latched |
| cfg_o | output | 320 | Stored configuration bytes, byte n at bits 8n+7:8n |

## Verification
The bench goes after the lock sequence in three ways: the key pair written back to back, the pair split by an intervening read, and a relock write. A design that only watched the last written value, or that ignored reads between the keys, would unlock when it should not. It runs a burst across the 0x7F boundary and a burst that starts on read-only addresses. A pointer that saturated, or that stalled on a discarded write, would put data at the wrong address. It reads the interrupt byte with an event pulsed, with an event held, and through a truncated frame. A design that cleared on load rather than on completion, or that cleared every bit, would lose events. It also checks that MISO stays low until the falling edge after the command byte, and that SPI clock activity with chip select high changes nothing.

// File: rtl/spi_regport_pkg.sv
// Package: shared constants and address-class helpers for the SPI register port.
// Assumes a 7-bit address and byte-wide registers.
package spi_regport_pkg;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int NREG     = 40;          // addresses with storage or decode: 0x00..0x27
    localparam int CNT_W    = $clog2(DATA_W);
    localparam logic [ADDR_W-1:0] ID_ADDR  = 7'h00;
    localparam logic [ADDR_W-1:0] INT_ADDR = 7'h0C;
    localparam logic [ADDR_W-1:0] KEY_ADDR = 7'h10;
    localparam logic [ADDR_W-1:0] PROT_LO  = 7'h11;
    localparam logic [ADDR_W-1:0] PROT_HI  = 7'h27;
    localparam logic [DATA_W-1:0] ID_VAL   = 8'hA6;
    localparam logic [DATA_W-1:0] KEY_1ST  = 8'hBA;
    localparam logic [DATA_W-1:0] KEY_2ND  = 8'hBE;

    // Bits that have storage at a given address; the rest read as 0.
    function automatic logic [DATA_W-1:0] field_mask(input logic [ADDR_W-1:0] a);
        case (a)
            7'h01:   return 8'h03;
            7'h11:   return 8'h01;
            default: return 8'hFF;
        endcase
    endfunction

    // Plain configuration bytes: writable without a key.
    function automatic logic is_plain(input logic [ADDR_W-1:0] a);
        return (a > ID_ADDR) && (a < KEY_ADDR) && (a != INT_ADDR);
    endfunction

    // Key-protected configuration bytes.
    function automatic logic is_prot(input logic [ADDR_W-1:0] a);
        return (a >= PROT_LO) && (a <= PROT_HI);
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
// Module: two-flop synchronizer for one asynchronous SPI pin.
// Assumes the pin is stable for several system clocks between changes.
module spi_pin_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);
    logic meta_q;

    // Two-stage capture of the pin into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= RST_VAL;
            level_o <= RST_VAL;
        end else begin
            meta_q  <= pin_i;
            level_o <= meta_q;
        end
    end
endmodule

// File: rtl/spi_frame_engine.sv
// Module: SPI frame engine. Decodes the command byte, keeps the auto-increment
// pointer, emits per-byte write/read-complete strobes and shifts read data out.
// Assumes synchronized pins and SCLK idle low (sample on rise, launch on fall).
module spi_frame_engine
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_hold,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              miso
);
    logic              sclk_d;
    logic              rise, fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] tx_sh;
    logic              cmd_seen;
    logic              is_wr;
    logic              byte_done;

    assign rise      = sclk_s & ~sclk_d;
    assign fall      = ~sclk_s & sclk_d;
    assign byte_done = ~cs_n_s & rise & (bit_cnt == CNT_W'(DATA_W-1)) & cmd_seen;
    assign wdata     = {shreg[DATA_W-2:0], mosi_s};
    assign wr_stb    = byte_done & is_wr;
    assign rd_stb    = byte_done & ~is_wr;
    assign miso      = tx_sh[DATA_W-1];

    // Delayed SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Frame state: bit counting, command capture, pointer advance, TX shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            tx_sh    <= '0;
            rd_hold  <= '0;
            cmd_seen <= 1'b0;
            is_wr    <= 1'b0;
            ptr      <= '0;
        end else if (cs_n_s) begin
            bit_cnt  <= '0;
            tx_sh    <= '0;
            cmd_seen <= 1'b0;
        end else begin
            if (rise) begin
                shreg   <= wdata;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(DATA_W-1)) begin
                    if (!cmd_seen) begin
                        cmd_seen <= 1'b1;
                        is_wr    <= shreg[DATA_W-2];
                        ptr      <= {shreg[ADDR_W-2:0], mosi_s};
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end
            end
            if (fall) begin
                if (cmd_seen && !is_wr && bit_cnt == '0) begin
                    tx_sh   <= rd_data;
                    rd_hold <= rd_data;
                end else begin
                    tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && ptr == 7'h7F) |=> (ptr == 7'h00));

    // R12
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && fall && cmd_seen && !is_wr && bit_cnt == '0) |=> (miso == $past(rd_data[DATA_W-1])));
endmodule

// File: rtl/spi_reg_bank.sv
// Module: register storage, key lock, read decode and interrupt latch.
// Assumes at most one write or read-complete strobe per cycle from the engine.
module spi_reg_bank
    import spi_regport_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W-1:0]        rd_hold,
    input  logic                     wr_stb,
    input  logic                     rd_stb,
    input  logic [DATA_W-1:0]        int_event,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     irq_pending,
    output logic [NREG*DATA_W-1:0]   cfg_flat
);
    logic [DATA_W-1:0] store [NREG];
    logic [DATA_W-1:0] int_q;
    logic              unlocked;
    logic              armed;
    logic              wr_ok;
    logic [DATA_W-1:0] int_clr;

    assign wr_ok       = is_plain(addr) || (is_prot(addr) && unlocked);
    assign int_clr     = (rd_stb && addr == INT_ADDR) ? rd_hold : '0;
    assign irq_pending = |int_q;

    // Flatten stored bytes for neighbouring logic.
    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign cfg_flat[g*DATA_W +: DATA_W] = store[g];
    end

    // Byte storage with field masking; only permitted addresses take writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) store[i] <= '0;
        end else if (wr_stb && wr_ok) begin
            for (int i = 0; i < NREG; i++) begin
                if (addr == ADDR_W'(i)) store[i] <= wdata & field_mask(ADDR_W'(i));
            end
        end
    end

    // Two-write key sequence; any other byte operation breaks it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            armed    <= 1'b0;
        end else if (wr_stb && addr == KEY_ADDR) begin
            if (wdata == KEY_1ST) begin
                armed    <= 1'b1;
                unlocked <= 1'b0;
            end else if (wdata == KEY_2ND && armed) begin
                armed    <= 1'b0;
                unlocked <= 1'b1;
            end else begin
                armed    <= 1'b0;
                unlocked <= 1'b0;
            end
        end else if (wr_stb || rd_stb) begin
            armed <= 1'b0;
        end
    end

    // Sticky interrupt status; clears only bits returned by a completed read.
    always_ff @(posedge clk) begin
        if (!rst_n) int_q <= '0;
        else        int_q <= (int_q & ~int_clr) | int_event;
    end

    // Read decode for the byte about to be shifted out.
    always_comb begin
        rd_data = '0;
        if (addr == ID_ADDR)                   rd_data = ID_VAL;
        else if (addr == INT_ADDR)             rd_data = int_q;
        else if (addr == KEY_ADDR)             rd_data = {{(DATA_W-1){1'b0}}, unlocked};
        else if (is_plain(addr) || is_prot(addr)) begin
            for (int i = 0; i < NREG; i++) begin
                if (addr == ADDR_W'(i)) rd_data = store[i];
            end
        end
    end

    // R6
    locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && is_prot(addr) && !unlocked) |=>
        $stable(cfg_flat[PROT_HI*DATA_W+DATA_W-1 : PROT_LO*DATA_W]));

    // R7
    unlock_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(armed));

    // R9
    int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && addr == INT_ADDR && int_event == '0) |=> ((int_q & $past(rd_hold)) == '0));
endmodule

// File: rtl/spi_regport.sv
// Module: top of the SPI register port. Synchronizes the pins, runs the frame
// engine and the register bank. Assumes SCLK half period >= 8 system clocks.
module spi_regport
    import spi_regport_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_sclk,
    input  logic                   spi_cs_n,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic                   spi_miso_oe,
    input  logic [7:0]             int_event_i,
    output logic                   irq_pending_o,
    output logic [NREG*8-1:0]      cfg_o
);
    logic              cs_n_s, sclk_s, mosi_s;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] wdata, rd_hold, rd_data;
    logic              wr_stb, rd_stb;

    spi_pin_sync #(.RST_VAL(1'b1)) u_sync_cs   (.clk(clk), .rst_n(rst_n), .pin_i(spi_cs_n), .level_o(cs_n_s));
    spi_pin_sync #(.RST_VAL(1'b0)) u_sync_sclk (.clk(clk), .rst_n(rst_n), .pin_i(spi_sclk), .level_o(sclk_s));
    spi_pin_sync #(.RST_VAL(1'b0)) u_sync_mosi (.clk(clk), .rst_n(rst_n), .pin_i(spi_mosi), .level_o(mosi_s));

    spi_frame_engine u_engine (
        .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
        .rd_data(rd_data), .ptr(ptr), .wdata(wdata), .rd_hold(rd_hold),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .miso(spi_miso)
    );

    spi_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .addr(ptr), .wdata(wdata), .rd_hold(rd_hold),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .int_event(int_event_i),
        .rd_data(rd_data), .irq_pending(irq_pending_o), .cfg_flat(cfg_o)
    );

    assign spi_miso_oe = ~cs_n_s;

    // R1
    cs_idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);
endmodule

// File: tb/spi_regport_tb.sv
module spi_regport_tb;
    localparam int H = 8;   // system clocks per SCLK half period

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic         miso, miso_oe, irq;
    logic [7:0]   int_ev = '0;
    logic [319:0] cfg;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] tx_buf [16];
    logic [7:0] act_q [$];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       pre_miso;

    spi_regport u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .int_event_i(int_ev),
        .irq_pending_o(irq), .cfg_o(cfg)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_rd(input string tag, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    // Drives one frame; cut > 0 stops after that many data bits.
    task automatic frame(input logic wr, input logic [6:0] addr, input int nbytes, input int cut);
        logic [7:0] cmd;
        logic [7:0] rx;
        int sent;
        cmd = {wr, addr};
        sent = 0;
        cs_n = 1'b0;
        wait_h();
        chk("R1 oe during frame", miso_oe, 1'b1);
        for (int b = 7; b >= 0; b--) begin
            mosi = cmd[b];
            wait_h();
            sclk = 1'b1;
            wait_h();
            if (b == 0) pre_miso = miso;
            sclk = 1'b0;
        end
        for (int k = 0; k < nbytes; k++) begin
            rx = '0;
            for (int b = 7; b >= 0; b--) begin
                if (cut > 0 && sent == cut) break;
                mosi = tx_buf[k][b];
                wait_h();
                rx[b] = miso;
                sclk = 1'b1;
                wait_h();
                sclk = 1'b0;
                sent++;
            end
            if (cut > 0 && sent == cut) break;
            if (!wr) act_q.push_back(rx);
        end
        wait_h();
        cs_n = 1'b1;
        repeat (3) wait_h();
    endtask

    task automatic wr1(input logic [6:0] a, input logic [7:0] d);
        tx_buf[0] = d;
        frame(1'b1, a, 1, 0);
    endtask

    task automatic rd1(input logic [6:0] a, input string tag, input logic [7:0] v);
        expect_rd(tag, v);
        tx_buf[0] = 8'h00;
        frame(1'b0, a, 1, 0);
    endtask

    // Scoreboard monitor: compares read bytes in order as they arrive.
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R13 reset state
        chk("R13 oe after reset", miso_oe, 1'b0);
        chk("R13 irq after reset", irq, 1'b0);
        chk("R13 cfg after reset", (cfg == '0), 1'b1);
        rd1(7'h10, "R13 locked after reset", 8'h00);

        // R5 / R3 / R12 ID byte and first-bit timing
        rd1(7'h00, "R5 ID read", 8'hA6);
        chk("R12 miso low before first data fall", pre_miso, 1'b0);
        wr1(7'h00, 8'h55);
        rd1(7'h00, "R5 ID after write", 8'hA6);

        // R11 field mask
        wr1(7'h01, 8'hFF);
        rd1(7'h01, "R11 masked byte", 8'h03);
        chk("R11 cfg byte1", cfg[8 +: 8], 8'h03);

        // R4 / R2 burst write then burst read
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
        frame(1'b1, 7'h02, 3, 0);
        expect_rd("R4 burst b0", 8'h11);
        expect_rd("R4 burst b1", 8'h22);
        expect_rd("R2 burst b2", 8'h33);
        frame(1'b0, 7'h02, 3, 0);

        // R4 wrap; R5 discarded write still advances pointer
        tx_buf[0] = 8'h99; tx_buf[1] = 8'h77; tx_buf[2] = 8'h02;
        frame(1'b1, 7'h7F, 3, 0);
        expect_rd("R6 high address reads 0", 8'h00);
        expect_rd("R4 wrap to ID", 8'hA6);
        expect_rd("R5 pointer advanced past RO", 8'h02);
        frame(1'b0, 7'h7F, 3, 0);

        // R6 locked write discarded
        wr1(7'h12, 8'h5A);
        rd1(7'h12, "R6 locked write", 8'h00);

        // R7 / R8 unlock
        wr1(7'h10, 8'hBA);
        wr1(7'h10, 8'hBE);
        rd1(7'h10, "R8 unlocked status", 8'h01);
        wr1(7'h12, 8'h5A);
        rd1(7'h12, "R7 write after unlock", 8'h5A);
        chk("R7 cfg byte 0x12", cfg[8'h12*8 +: 8], 8'h5A);
        wr1(7'h11, 8'hFF);
        rd1(7'h11, "R11 protected masked byte", 8'h01);

        // R8 relock
        wr1(7'h10, 8'h00);
        rd1(7'h10, "R8 relocked status", 8'h00);
        wr1(7'h12, 8'h11);
        rd1(7'h12, "R8 write after relock", 8'h5A);

        // R7 sequence broken by a read
        wr1(7'h10, 8'hBA);
        rd1(7'h05, "R7 intervening read", 8'h00);
        wr1(7'h10, 8'hBE);
        rd1(7'h10, "R7 broken sequence stays locked", 8'h00);

        // R10 key sequence broken by a partial byte does not count either way
        wr1(7'h10, 8'hBA);
        tx_buf[0] = 8'hBE;
        frame(1'b1, 7'h10, 1, 4);
        wr1(7'h10, 8'hBE);
        rd1(7'h10, "R10 partial byte not an operation", 8'h01);
        wr1(7'h10, 8'h00);

        // R9 interrupt latch and clear-on-read
        @(negedge clk); int_ev = 8'h05;
        @(negedge clk); int_ev = 8'h00;
        repeat (3) @(negedge clk);
        chk("R9 irq set", irq, 1'b1);
        rd1(7'h0C, "R9 latched events", 8'h05);
        chk("R9 irq cleared", irq, 1'b0);
        rd1(7'h0C, "R9 cleared after read", 8'h00);
        @(negedge clk); int_ev = 8'h80;
        rd1(7'h0C, "R9 persistent event", 8'h80);
        rd1(7'h0C, "R9 persistent event sets again", 8'h80);
        @(negedge clk); int_ev = 8'h00;
        rd1(7'h0C, "R9 last latched", 8'h80);
        rd1(7'h0C, "R9 released", 8'h00);

        // R10 partial read does not clear; partial write does not commit
        @(negedge clk); int_ev = 8'h02;
        @(negedge clk); int_ev = 8'h00;
        tx_buf[0] = 8'h00;
        frame(1'b0, 7'h0C, 1, 4);
        rd1(7'h0C, "R10 partial read kept status", 8'h02);
        tx_buf[0] = 8'hEE;
        frame(1'b1, 7'h03, 1, 5);
        rd1(7'h03, "R10 partial write dropped", 8'h22);

        // R1 pins ignored with chip select high
        for (int b = 0; b < 16; b++) begin
            mosi = b[0];
            wait_h();
            sclk = ~sclk;
        end
        sclk = 1'b0;
        chk("R1 oe with cs high", miso_oe, 1'b0);
        rd1(7'h03, "R1 no effect with cs high", 8'h22);

        repeat (20) @(negedge clk);
        if (exp_q.size() != 0) begin
            chk("scoreboard drained", exp_q.size(), 0);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule